// File: doc/BRIEF.md
# Core Power Mode Controller

This block selects the power mode of an embedded controller's core domain and drives that domain's clock controls. It has three modes. In Active the core runs from the high-frequency clock. In Idle the core clock is gated, and a few always-on modules run from the low-frequency clock. In Power Off the supply is gone and every clock control is low. Software requests Idle, and masked wake-up lines bring the core back. On the way back, the high-frequency generator starts first, and the core clock is ungated only once the generator reports a stable clock.

Inside Active there is also a wait-for-interrupt stall. A WAIT request halts instruction issue until an interrupt arrives, and the clock controls stay as they are. In Idle, software may switch the high-frequency generator off, but the generator stays on while another clock domain holds the keep-alive input. When the supply drops, the block goes to Power Off. Only a full reset brings it out again, and that reset lands in Active.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (Active), `hf_gen_en_o`=1, `core_hf_en_o`=1, `core_lf_sel_o`=0, `lf_osc_en_o`=1 and `stall_o`=0.
- R2: In Active with `idle_req_i` high and no enabled wake-up line, the next cycle shows `mode_o`=2'b01, `core_hf_en_o`=0, `core_lf_sel_o`=1 and `lf_osc_en_o`=1.
- R3: In Idle before any wake-up, `hf_gen_en_o` equals `!sw_hf_off_i | hf_keep_i`. It follows these inputs in the same cycle.
- R4: A wake-up line counts only when both `wake_i[k]` and `wake_en_i[k]` are high. In Idle, an enabled line starts the wake sequence on the next cycle: `hf_gen_en_o`=1 (whatever `sw_hf_off_i` is), `core_hf_en_o`=0 and `mode_o` still 2'b01. Lines that are not enabled leave Idle unchanged.
- R5: During the wake sequence, the first clock edge that sees `hf_stable_i` high returns the block to Active (`mode_o`=2'b00, `core_hf_en_o`=1, `core_lf_sel_o`=0). `core_hf_en_o` is never high while `hf_gen_en_o` is low.
- R6: In Active, `wait_req_i` sets `stall_o` on the next cycle, and `stall_o` then holds. `irq_i` clears it on the next cycle and wins over a simultaneous `wait_req_i`. Leaving Active clears it. No clock control changes because of the stall.
- R7: Enabled wake-up lines have no effect in Active. An Idle request together with an enabled wake-up line in the same cycle leaves the block in Active.
- R8: `supply_ok_i` low forces `mode_o`=2'b10 on the next cycle, from any mode. In that mode all clock controls and `stall_o` are 0. The mode stays there even after the supply returns, until `rst_ni` is asserted.
- R9: `mode_o` only ever carries 2'b00, 2'b01 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| supply_ok_i | input | 1 | Core supply good |
| idle_req_i | input | 1 | Software request to enter Idle |
| wait_req_i | input | 1 | Software WAIT request (stall until interrupt) |
| irq_i | input | 1 | Interrupt, ends a WAIT stall |
| wake_i | input | N_WAKE | Wake-up event lines |
| wake_en_i | input | N_WAKE | Per-line wake-up enable |
| sw_hf_off_i | input | 1 | Software request to stop the high-frequency generator in Idle |
| hf_keep_i | input | 1 | Another clock domain needs the high-frequency generator |
| hf_stable_i | input | 1 | High-frequency clock is stable |
| mode_o | output | 2 | Mode: 00 Active, 01 Idle, 10 Power Off |
| hf_gen_en_o | output | 1 | High-frequency generator enable |
| core_hf_en_o | output | 1 | Core clock gate from high-frequency clock |
| core_lf_sel_o | output | 1 | Always-on modules run from low-frequency clock |
| lf_osc_en_o | output | 1 | Low-frequency oscillator enable |
| stall_o | output | 1 | Instruction issue stalled by WAIT |

## Verification
A wrong mode state shows at the ports on the first cycle after the edge that took it. All clock controls are decoded straight from the state register, so a bad state appears there at once, as a gated or ungated core clock or a generator left off. A stall flag that was set wrongly or cleared too late shows on `stall_o` one cycle after the `wait_req_i` or `irq_i` edge. A failure to latch Power Off shows when the supply returns without a reset and `mode_o` leaves 2'b10.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_OFF    = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2,
    ST_DOWN  = 2'd3
  } state_e;
endpackage

// File: rtl/pwr_wake_detect.sv
`timescale 1ns/1ps
module pwr_wake_detect #(
  parameter int N_WAKE = 4
) (
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  output logic              wake_any_o
);
  logic [N_WAKE-1:0] hit;

  for (genvar g = 0; g < N_WAKE; g++) begin : g_line
    assign hit[g] = wake_i[g] & wake_en_i[g];
  end

  assign wake_any_o = |hit;
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   supply_ok_i,
  input  logic   idle_req_i,
  input  logic   wake_any_i,
  input  logic   hf_stable_i,
  output state_e state_o,
  output logic   run_next_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_DOWN;
    end else begin
      unique case (state_q)
        ST_RUN:   if (idle_req_i && !wake_any_i) state_d = ST_SLEEP;
        ST_SLEEP: if (wake_any_i) state_d = ST_WAKE;
        ST_WAKE:  if (hf_stable_i) state_d = ST_RUN;
        ST_DOWN:  state_d = ST_DOWN; // only reset leaves
        default:  state_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign run_next_o = (state_d == ST_RUN);
endmodule

// File: rtl/pwr_wait_stall.sv
`timescale 1ns/1ps
module pwr_wait_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_now_i,
  input  logic run_next_i,
  input  logic wait_req_i,
  input  logic irq_i,
  output logic stall_o
);
  logic stall_q, stall_d;

  always_comb begin
    if (!(run_now_i && run_next_i)) stall_d = 1'b0;
    else if (irq_i)                 stall_d = 1'b0;
    else                            stall_d = stall_q | wait_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_d;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
  import pwr_mode_pkg::*;
(
  input  state_e      state_i,
  input  logic        sw_hf_off_i,
  input  logic        hf_keep_i,
  output logic [1:0]  mode_o,
  output logic        hf_gen_en_o,
  output logic        core_hf_en_o,
  output logic        core_lf_sel_o,
  output logic        lf_osc_en_o
);
  mode_e mode;

  always_comb begin
    mode          = MODE_OFF;
    hf_gen_en_o   = 1'b0;
    core_hf_en_o  = 1'b0;
    core_lf_sel_o = 1'b0;
    lf_osc_en_o   = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        mode         = MODE_ACTIVE;
        hf_gen_en_o  = 1'b1;
        core_hf_en_o = 1'b1;
        lf_osc_en_o  = 1'b1;
      end
      ST_SLEEP: begin
        mode          = MODE_IDLE;
        hf_gen_en_o   = !sw_hf_off_i || hf_keep_i;
        core_lf_sel_o = 1'b1;
        lf_osc_en_o   = 1'b1;
      end
      ST_WAKE: begin
        // generator restarts first; core gate waits for stable
        mode          = MODE_IDLE;
        hf_gen_en_o   = 1'b1;
        core_lf_sel_o = 1'b1;
        lf_osc_en_o   = 1'b1;
      end
      default: mode = MODE_OFF;
    endcase
  end

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              idle_req_i,
  input  logic              wait_req_i,
  input  logic              irq_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic              sw_hf_off_i,
  input  logic              hf_keep_i,
  input  logic              hf_stable_i,
  output logic [1:0]        mode_o,
  output logic              hf_gen_en_o,
  output logic              core_hf_en_o,
  output logic              core_lf_sel_o,
  output logic              lf_osc_en_o,
  output logic              stall_o
);
  logic   wake_any;
  logic   run_next;
  state_e state;

  pwr_wake_detect #(.N_WAKE(N_WAKE)) u_wake (
    .wake_i     (wake_i),
    .wake_en_i  (wake_en_i),
    .wake_any_o (wake_any)
  );

  pwr_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .idle_req_i  (idle_req_i),
    .wake_any_i  (wake_any),
    .hf_stable_i (hf_stable_i),
    .state_o     (state),
    .run_next_o  (run_next)
  );

  pwr_wait_stall u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_now_i  (state == ST_RUN),
    .run_next_i (run_next),
    .wait_req_i (wait_req_i),
    .irq_i      (irq_i),
    .stall_o    (stall_o)
  );

  pwr_clk_ctrl u_clk (
    .state_i       (state),
    .sw_hf_off_i   (sw_hf_off_i),
    .hf_keep_i     (hf_keep_i),
    .mode_o        (mode_o),
    .hf_gen_en_o   (hf_gen_en_o),
    .core_hf_en_o  (core_hf_en_o),
    .core_lf_sel_o (core_lf_sel_o),
    .lf_osc_en_o   (lf_osc_en_o)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int N_WAKE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              supply_ok_i,
  input logic              idle_req_i,
  input logic              irq_i,
  input logic [N_WAKE-1:0] wake_i,
  input logic [N_WAKE-1:0] wake_en_i,
  input logic              hf_keep_i,
  input logic [1:0]        mode_o,
  input logic              hf_gen_en_o,
  input logic              core_hf_en_o,
  input logic              lf_osc_en_o,
  input logic              stall_o
);
  logic wake_hit;
  assign wake_hit = |(wake_i & wake_en_i);

  a_r9_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  a_r8_supply_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> mode_o == 2'b10);

  a_r8_off_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |=> mode_o == 2'b10);

  a_r8_off_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> !hf_gen_en_o && !core_hf_en_o && !lf_osc_en_o && !stall_o);

  a_r2_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && supply_ok_i && idle_req_i && !wake_hit) |=> mode_o == 2'b01);

  a_r7_idle_vs_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && supply_ok_i && idle_req_i && wake_hit) |=> mode_o == 2'b00);

  a_r3_keep_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && hf_keep_i) |-> hf_gen_en_o);

  a_r5_gate_needs_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_hf_en_o |-> hf_gen_en_o);

  a_r6_irq_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !stall_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_WAKE(N_WAKE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supply_ok_i  (supply_ok_i),
  .idle_req_i   (idle_req_i),
  .irq_i        (irq_i),
  .wake_i       (wake_i),
  .wake_en_i    (wake_en_i),
  .hf_keep_i    (hf_keep_i),
  .mode_o       (mode_o),
  .hf_gen_en_o  (hf_gen_en_o),
  .core_hf_en_o (core_hf_en_o),
  .lf_osc_en_o  (lf_osc_en_o),
  .stall_o      (stall_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int NW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok_i = 1'b1, idle_req_i = 1'b0, wait_req_i = 1'b0, irq_i = 1'b0;
  logic [NW-1:0] wake_i = '0, wake_en_i = '0;
  logic sw_hf_off_i = 1'b0, hf_keep_i = 1'b0, hf_stable_i = 1'b0;
  logic [1:0] mode_o;
  logic hf_gen_en_o, core_hf_en_o, core_lf_sel_o, lf_osc_en_o, stall_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [6:0] v;   // {mode, hf_gen, core_hf, lf_sel, lf_osc, stall}
    string      tag;
  } exp_t;

  exp_t q[$];

  always #5 clk_i = ~clk_i;

  pwr_mode_ctrl #(.N_WAKE(NW)) u_dut (
    .clk_i, .rst_ni, .supply_ok_i, .idle_req_i, .wait_req_i, .irq_i,
    .wake_i, .wake_en_i, .sw_hf_off_i, .hf_keep_i, .hf_stable_i,
    .mode_o, .hf_gen_en_o, .core_hf_en_o, .core_lf_sel_o, .lf_osc_en_o, .stall_o
  );

  function automatic logic [6:0] outs();
    return {mode_o, hf_gen_en_o, core_hf_en_o, core_lf_sel_o, lf_osc_en_o, stall_o};
  endfunction

  function automatic void cmp(input logic [6:0] act, input logic [6:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endfunction

  // one cycle: drive at negedge, expect result after next posedge
  task automatic drv(input logic s, input logic il, input logic wr, input logic iq,
                     input logic [NW-1:0] wk, input logic [NW-1:0] we,
                     input logic ho, input logic kp, input logic stb,
                     input logic [6:0] e, input string tag);
    exp_t x;
    @(negedge clk_i);
    supply_ok_i = s; idle_req_i = il; wait_req_i = wr; irq_i = iq;
    wake_i = wk; wake_en_i = we; sw_hf_off_i = ho; hf_keep_i = kp; hf_stable_i = stb;
    x.v = e; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        cmp(outs(), x.v, x.tag);
      end
    end
  end

  // expected vectors
  localparam logic [6:0] ACT   = 7'b00_1_1_0_1_0;
  localparam logic [6:0] ACT_S = 7'b00_1_1_0_1_1;
  localparam logic [6:0] IDL   = 7'b01_1_0_1_1_0;
  localparam logic [6:0] IDL_G = 7'b01_0_0_1_1_0;
  localparam logic [6:0] OFF   = 7'b10_0_0_0_0_0;

  initial begin
    #1;
    cmp(outs(), ACT, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    drv(1,0,0,0,4'b0000,4'b0000,0,0,0, ACT,   "R1 after reset");
    drv(1,0,0,0,4'b0001,4'b0001,0,0,0, ACT,   "R7 wake in active");
    drv(1,1,0,0,4'b0010,4'b0010,0,0,0, ACT,   "R7 idle+wake");
    drv(1,0,1,0,4'b0000,4'b0000,0,0,0, ACT_S, "R6 wait sets");
    drv(1,0,0,0,4'b0000,4'b0000,0,0,0, ACT_S, "R6 stall holds");
    drv(1,0,1,1,4'b0000,4'b0000,0,0,0, ACT,   "R6 irq wins");
    drv(1,0,1,0,4'b0000,4'b0000,0,0,0, ACT_S, "R6 wait again");
    drv(1,0,0,1,4'b0000,4'b0000,0,0,0, ACT,   "R6 irq clears");
    drv(1,1,0,0,4'b0100,4'b0000,0,0,0, IDL,   "R2 enter idle");
    drv(1,0,0,0,4'b0000,4'b0000,1,0,0, IDL_G, "R3 gen off");
    drv(1,0,0,0,4'b0000,4'b0000,1,1,0, IDL,   "R3 keep alive");
    drv(1,0,0,0,4'b1000,4'b0111,1,0,0, IDL_G, "R4 masked wake");
    drv(1,0,0,0,4'b1000,4'b1000,1,0,0, IDL,   "R4 wake starts gen");
    drv(1,0,0,0,4'b0000,4'b0000,1,0,0, IDL,   "R4 wait stable");
    drv(1,0,0,0,4'b0000,4'b0000,1,0,1, ACT,   "R5 stable ungates");
    drv(1,0,1,0,4'b0000,4'b0000,0,0,0, ACT_S, "R6 wait before idle");
    drv(1,1,0,0,4'b0000,4'b0000,0,0,0, IDL,   "R6 leave active clears");
    drv(0,0,0,0,4'b0000,4'b0000,0,0,0, OFF,   "R8 supply lost idle");
    drv(1,0,0,0,4'b0000,4'b0000,0,0,0, OFF,   "R8 sticky");
    drv(1,0,0,0,4'b1111,4'b1111,0,0,1, OFF,   "R8 wake ignored off");
    @(negedge clk_i);
    rst_ni = 1'b0;
    supply_ok_i = 1'b1; wake_i = '0; wake_en_i = '0; hf_stable_i = 1'b0;
    #1;
    cmp(outs(), ACT, "R1 reset from off");
    @(negedge clk_i);
    rst_ni = 1'b1;
    drv(1,0,0,0,4'b0000,4'b0000,0,0,0, ACT,   "R1 active again");
    drv(0,0,1,0,4'b0000,4'b0000,0,0,0, OFF,   "R8 supply lost active");
    drv(0,0,0,0,4'b0000,4'b0000,0,0,0, OFF,   "R9 off code");
    @(posedge clk_i);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule